// File: doc/BRIEF.md
# Multiplexer-Skip Carry-Skip Adder

A purely combinational adder of two `WIDTH`-bit operands plus a carry-in. The operand width is cut into `WIDTH/BLK` equal groups of `BLK` bits. Inside a group the carry ripples one bit at a time. Each bit forwards its incoming carry when it propagates and otherwise passes on its `y` bit, which then equals the generated carry.

Each group also forms a group-propagate flag. This flag is the AND of its bit propagates, built as a chain of multiplexers. A 2:1 multiplexer at the group's output drives the carry into the next group. It drives the carry that entered the group when the flag is set, and the carry that rippled through the group otherwise. Because the bypass is a selection and not an OR with the rippled carry, the result never depends on earlier signal values.

The fastest fixed group size lies near the square root of `WIDTH/2`. The defaults are `WIDTH = 32` and `BLK = 4`, where the worst path is about 12.5 ripple stages instead of 32. A group size that does not divide the width stops elaboration.

Top module: `csk_adder`

## Requirements
- R1: For every input, `{cout, sum}` equals `x + y + cin` taken as an unsigned `WIDTH+1`-bit value.
- R2: The carry-in enters the lowest group: with `x = y = 0`, `sum` equals `cin` (bit 0 only) and `cout` is 0.
- R3: When every bit of a group propagates (`x[i] != y[i]` for all its bits), that group's outgoing carry equals its incoming carry. So with `y = ~x`, `sum` is all ones and `cout` is 0 for `cin = 0`, and `sum` is all zeros and `cout` is 1 for `cin = 1`.
- R4: When a group does not fully propagate, its outgoing carry does not depend on its incoming carry. It equals the carry out of the group's own bits added with a carry-in of 0.
- R5: `cout` is bit `WIDTH` of the true sum, for example 1 for all-ones plus zero with `cin = 1`.
- R6: The configuration with one group (`BLK = WIDTH`) gives the same results as R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | WIDTH | first operand |
| y | input | WIDTH | second operand |
| cin | input | 1 | carry into bit 0 |
| sum | output | WIDTH | sum bits |
| cout | output | 1 | carry out of the top bit |

## Verification
The block holds no register, so every result is due in the same cycle as the operands that produce it, zero clock edges later. The bench drives a new operand set just after a falling clock edge. It samples `sum` and `cout` one nanosecond later, still inside that half cycle, so the checks never straddle an edge. Three 8-bit configurations (group sizes 2, 4 and 8) are swept over all operand pairs and both carry-in values. The 32-bit default gets the replicated sweep patterns plus random and group-aligned propagate and generate patterns.

// File: rtl/csk_pkg.sv
package csk_pkg;
  // One ripple step: pass the incoming carry if the bit propagates,
  // otherwise the y bit is the generated (or killed) carry.
  function automatic logic ripple_step(input logic p, input logic c, input logic yb);
    return p ? c : yb;
  endfunction

  // One step of the group-propagate chain.
  function automatic logic prop_step(input logic p, input logic run);
    return p ? run : 1'b0;
  endfunction
endpackage

// File: rtl/csk_skip_mux.sv
module csk_skip_mux (
  input  logic grp_prop,
  input  logic c_enter,
  input  logic c_ripple,
  output logic c_leave
);
  always_comb begin
    if (grp_prop) c_leave = c_enter;
    else          c_leave = c_ripple;
  end
endmodule

// File: rtl/csk_group.sv
module csk_group #(
  parameter int BLK = 4
) (
  input  logic [BLK-1:0] xa,
  input  logic [BLK-1:0] yb,
  input  logic           c_in,
  output logic [BLK-1:0] s,
  output logic           c_out,
  output logic           gprop
);
  import csk_pkg::*;

  logic [BLK-1:0] p;
  logic [BLK:0]   rc;
  logic [BLK:0]   pc;

  assign rc[0] = c_in;
  assign pc[0] = 1'b1;

  for (genvar i = 0; i < BLK; i++) begin : g_bit
    assign p[i]    = xa[i] ^ yb[i];
    assign s[i]    = p[i] ^ rc[i];
    assign rc[i+1] = ripple_step(p[i], rc[i], yb[i]);
    assign pc[i+1] = prop_step(p[i], pc[i]);
  end

  assign gprop = pc[BLK];

  csk_skip_mux u_skip (
    .grp_prop (gprop),
    .c_enter  (c_in),
    .c_ripple (rc[BLK]),
    .c_leave  (c_out)
  );
endmodule

// File: rtl/csk_adder.sv
module csk_adder #(
  parameter int WIDTH = 32,
  parameter int BLK   = 4
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NGRP = WIDTH / BLK;

  if (BLK < 1 || (WIDTH % BLK) != 0) begin : g_bad_cfg
    $error("csk_adder: BLK must divide WIDTH");
  end

  logic [NGRP:0]   chain;
  logic [NGRP-1:0] grp_cin;
  logic [NGRP-1:0] grp_cout;
  logic [NGRP-1:0] grp_prop;

  assign chain[0] = cin;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    csk_group #(.BLK(BLK)) u_grp (
      .xa    (x[g*BLK +: BLK]),
      .yb    (y[g*BLK +: BLK]),
      .c_in  (chain[g]),
      .s     (sum[g*BLK +: BLK]),
      .c_out (chain[g+1]),
      .gprop (grp_prop[g])
    );
  end

  assign grp_cin  = chain[NGRP-1:0];
  assign grp_cout = chain[NGRP:1];
  assign cout     = chain[NGRP];
endmodule

// File: rtl/csk_adder_chk.sv
module csk_adder_chk #(
  parameter int WIDTH = 32,
  parameter int BLK   = 4
) (
  input logic [WIDTH-1:0]      x,
  input logic [WIDTH-1:0]      y,
  input logic                  cin,
  input logic [WIDTH-1:0]      sum,
  input logic                  cout,
  input logic [WIDTH/BLK-1:0]  grp_cin,
  input logic [WIDTH/BLK-1:0]  grp_cout,
  input logic [WIDTH/BLK-1:0]  grp_prop
);
  localparam int NGRP = WIDTH / BLK;

  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    assert_sum_R1: assert ({cout, sum} == ref_sum)
      else $error("R1 sum mismatch");
    assert_cout_R5: assert (cout == ref_sum[WIDTH])
      else $error("R5 carry-out mismatch");
    assert_cin_R2: assert (((x == '0) && (y == '0)) ? (sum[0] == cin && !cout) : 1'b1)
      else $error("R2 carry-in not in lowest group");
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp_chk
    logic [BLK:0] own;
    assign own = {1'b0, x[g*BLK +: BLK]} + {1'b0, y[g*BLK +: BLK]};
    always_comb begin
      assert_skip_R3: assert (grp_prop[g] == ((x[g*BLK +: BLK] ^ y[g*BLK +: BLK]) == {BLK{1'b1}})
                              && (!grp_prop[g] || grp_cout[g] == grp_cin[g]))
        else $error("R3 group skip wrong");
      assert_kill_R4: assert (grp_prop[g] || grp_cout[g] == own[BLK])
        else $error("R4 group carry depends on incoming carry");
    end
  end
endmodule

bind csk_adder csk_adder_chk #(.WIDTH(WIDTH), .BLK(BLK)) u_chk (
  .x(x), .y(y), .cin(cin), .sum(sum), .cout(cout),
  .grp_cin(grp_cin), .grp_cout(grp_cout), .grp_prop(grp_prop)
);

// File: tb/csk_adder_bench.sv
`timescale 1ns/1ps
module csk_adder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] x32, y32;
  logic [7:0]  x8, y8;
  logic        cin;
  logic [31:0] s32;
  logic        c32;
  logic [7:0]  s8b2, s8b4, s8b8;
  logic        c8b2, c8b4, c8b8;

  csk_adder #(.WIDTH(32), .BLK(4)) u_csk_adder (
    .x(x32), .y(y32), .cin(cin), .sum(s32), .cout(c32));
  csk_adder #(.WIDTH(8), .BLK(2)) u_csk_adder_w8b2 (
    .x(x8), .y(y8), .cin(cin), .sum(s8b2), .cout(c8b2));
  csk_adder #(.WIDTH(8), .BLK(4)) u_csk_adder_w8b4 (
    .x(x8), .y(y8), .cin(cin), .sum(s8b4), .cout(c8b4));
  csk_adder #(.WIDTH(8), .BLK(8)) u_csk_adder_w8b8 (
    .x(x8), .y(y8), .cin(cin), .sum(s8b8), .cout(c8b8));

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (x32=%h y32=%h x8=%h y8=%h cin=%b)",
               req, act, exp, x32, y32, x8, y8, cin);
    end
  endtask

  function automatic logic [32:0] add32(input logic [31:0] a, input logic [31:0] b, input logic c);
    return {1'b0, a} + {1'b0, b} + {32'd0, c};
  endfunction

  function automatic logic [32:0] add8(input logic [7:0] a, input logic [7:0] b, input logic c);
    logic [8:0] r;
    r = {1'b0, a} + {1'b0, b} + {8'd0, c};
    return {24'd0, r};
  endfunction

  task automatic check32(input string req);
    check(req, {c32, s32}, add32(x32, y32, cin));
  endtask

  task automatic step32(input logic [31:0] a, input logic [31:0] b, input logic c, input string req);
    @(negedge clk);
    x32 = a; y32 = b; cin = c;
    #1;
    check32(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    x32 = '0; y32 = '0; x8 = '0; y8 = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: zero operands give zero results (R1, R2)
    @(negedge clk); #1;
    check("R2 idle 32", {c32, s32}, 33'd0);
    check("R2 idle 8x2", {24'd0, c8b2, s8b2}, 33'd0);

    // R2: carry-in lands in bit 0 only
    step32('0, '0, 1'b1, "R2 cin into bit0");
    check("R2 cin value", {c32, s32}, 33'd1);
    x8 = '0; y8 = '0; #1;
    check("R2 cin 8x8", {24'd0, c8b8, s8b8}, 33'd1);

    // R3: all groups propagate, both carry-in values
    for (int k = 0; k < 200; k++) begin
      logic [31:0] a;
      a = $urandom;
      step32(a, ~a, 1'b0, "R3 full propagate cin0");
      check("R3 all ones", {c32, s32}, {1'b0, 32'hFFFF_FFFF});
      step32(a, ~a, 1'b1, "R3 full propagate cin1");
      check("R3 wrap to zero", {c32, s32}, {1'b1, 32'h0});
    end

    // R3: one group propagates, carry from below must skip through it
    for (int g = 0; g < 8; g++) begin
      for (int k = 0; k < 40; k++) begin
        logic [31:0] a, b;
        a = $urandom; b = $urandom;
        b[g*4 +: 4] = ~a[g*4 +: 4];
        step32(a, b, k[0], "R3 single group skip");
      end
    end

    // R4: a group that generates or kills regardless of the carry below
    for (int g = 0; g < 8; g++) begin
      for (int k = 0; k < 40; k++) begin
        logic [31:0] a, b;
        a = $urandom; b = $urandom;
        b[g*4 +: 4] = a[g*4 +: 4];
        step32(a, b, k[0], "R4 group generate/kill");
      end
    end

    // R5: carry-out boundaries
    step32(32'hFFFF_FFFF, 32'h0, 1'b1, "R5 cout all ones plus cin");
    check("R5 cout set", {32'd0, c32}, 33'd1);
    step32(32'hFFFF_FFFF, 32'h0, 1'b0, "R5 cout clear");
    check("R5 cout zero", {32'd0, c32}, 33'd0);
    step32(32'h8000_0000, 32'h8000_0000, 1'b0, "R5 cout from top bit");
    check("R5 top generate", {32'd0, c32}, 33'd1);

    // Exhaustive 8-bit sweep on three group sizes (R1, R6), 32-bit replicated
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        for (int c = 0; c < 2; c++) begin
          @(negedge clk);
          x8 = a[7:0]; y8 = b[7:0]; cin = c[0];
          x32 = {4{a[7:0]}}; y32 = {4{b[7:0]}};
          #1;
          check("R1 8x2", {24'd0, c8b2, s8b2}, add8(x8, y8, cin));
          check("R1 8x4", {24'd0, c8b4, s8b4}, add8(x8, y8, cin));
          check("R6 8x8 single group", {24'd0, c8b8, s8b8}, add8(x8, y8, cin));
          check32("R1 32x4 sweep");
        end
      end
    end

    finish_run();
  end
endmodule